// File: doc/BRIEF.md
# Byte SPI Master with Register Interface

This block is a serial peripheral interface master that moves one byte at a time. Software reaches it over a flat 32-bit register bus with a write strobe, a read strobe, a byte address and data in both directions. Every access completes in the cycle it is presented. The bus has no back-pressure and no valid/ready handshake. Software must instead poll the busy flag before it launches the next byte.

A write to the transmit register starts a full-duplex exchange of eight bits, most significant bit first. The serial clock comes from two stages. A prescaler picks one of two powers of two, and a programmable stage then divides by 2×(N+1). Clock polarity and clock phase are both programmable, so all four SPI modes are available. When the exchange ends, the byte taken in from the slave is held in the receive register and a ready flag is raised. Chip select is a plain register bit that software drives; the block never moves it by itself.

Top module: `spi_mst_top`

## Requirements
- R1: After synchronous reset the control register (0x00) and the status register (0x04) read 0, the system register (0x08) reads 0x40, cs_n is high and sck is low.
- R2: The control register keeps bits [7:0]. Bit 7 is phase, bit 6 is polarity, bit 5 is the prescaler select and bits [4:0] are N. The system register keeps bits 0, 5 and 6. Every other register bit reads 0, and so does every undefined offset, including 0x14 and 0x18.
- R3: A write to 0x0C starts an 8-bit exchange, MSB first on mosi. It does so only when system bit 0 is 1 and status bit 0 is 0. If system bit 0 is 0, the write is ignored and status stays 0.
- R4: Status bit 0 is 1 for exactly 16×H cycles, counted from the cycle after the transmit write. H = (N+1)·2^PRE_LO_LOG2 when control bit 5 is 0, and H = (N+1)·2^PRE_HI_LOG2 when it is 1.
- R5: sck makes exactly 16 edges per byte and rests at the polarity bit whenever status bit 0 is 0. With phase 0, miso is sampled on the leading edges and mosi changes on the trailing edges. With phase 1, mosi changes on the leading edges after the first one, and miso is sampled on the trailing edges.
- R6: At the end of an exchange the received byte goes into 0x10 (bits [7:0]) and status bit 2 is set. A read of 0x10 clears status bit 2.
- R7: A write to 0x04 with data bit 2 equal to 0 clears status bit 2.
- R8: cs_n always equals system bit 6.
- R9: While status bit 0 is 1, writes to 0x00 and to 0x0C are ignored. The control value is kept and the exchange in flight is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip select, active low, set by software |

## Verification
The bench builds the block with PRE_LO_LOG2=1 and PRE_HI_LOG2=2, so the two prescalers divide by 2 and by 4. At these values even the slowest setting takes about 2048 cycles per byte. That makes it affordable to sweep all 64 divider codes, cycling through the four modes, and to compare each busy window with 16×H computed in the bench. At the fastest divider, every one of the 256 byte values is exchanged in each of the four modes against a bench slave model, and both directions are checked.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_SYS  = 'h08;
  localparam int OFF_TX   = 'h0C;
  localparam int OFF_RX   = 'h10;

  localparam int FRAME_BITS = 8;

  // control register image, bit positions match the register
  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic       presel;
    logic [4:0] ndiv;
  } ctrl_t;
endpackage

// File: rtl/spi_mst_clkgen.sv
module spi_mst_clkgen #(
  parameter int PRE_LO_LOG2 = 4,
  parameter int PRE_HI_LOG2 = 7,
  parameter int NDIV_W      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              presel,
  input  logic [NDIV_W-1:0] ndiv,
  output logic              tick
);
  localparam int CW = PRE_HI_LOG2 + NDIV_W + 1;

  logic [CW-1:0] base;
  logic [CW-1:0] half;
  logic [CW-1:0] limit;
  logic [CW-1:0] cnt;

  always_comb begin
    base  = CW'(ndiv) + CW'(1);
    half  = presel ? (base << PRE_HI_LOG2) : (base << PRE_LO_LOG2);
    limit = half - CW'(1);
  end

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == limit) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi_mst_shifter.sv
module spi_mst_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            cpha,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rx_word,
  output logic            sck_ph,
  output logic            mosi
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES);

  logic [EW-1:0]   edge_cnt;
  logic [BITS-1:0] txsr;
  logic [BITS-1:0] rxsr;
  logic            leading;
  logic            do_sample;
  logic            do_shift;

  always_comb begin
    leading   = !edge_cnt[0];
    do_sample = cpha ? !leading : leading;
    do_shift  = cpha ? (leading && (edge_cnt != '0)) : !leading;
  end

  assign done    = busy && tick && (edge_cnt == EW'(EDGES - 1));
  assign rx_word = cpha ? {rxsr[BITS-2:0], miso} : rxsr;
  assign mosi    = txsr[BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
      txsr     <= '0;
      rxsr     <= '0;
      sck_ph   <= 1'b0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      edge_cnt <= '0;
      txsr     <= tx_byte;
      sck_ph   <= 1'b0;
    end else if (busy && tick) begin
      sck_ph   <= !sck_ph;
      edge_cnt <= edge_cnt + EW'(1);
      if (do_sample) rxsr <= {rxsr[BITS-2:0], miso};
      if (do_shift)  txsr <= {txsr[BITS-2:0], 1'b0};
      if (edge_cnt == EW'(EDGES - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_mst_regs.sv
module spi_mst_regs
  import spi_mst_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  busy,
  input  logic                  done,
  input  logic [FRAME_BITS-1:0] rx_word,
  output ctrl_t                 ctrl,
  output logic                  start,
  output logic [FRAME_BITS-1:0] tx_byte,
  output logic                  cs_n,
  output logic                  rdy
);
  logic hit_ctrl, hit_stat, hit_sys, hit_tx, hit_rx;
  logic sys_en, sys_sw, sys_cs;
  logic [FRAME_BITS-1:0] rx_q;

  always_comb begin
    hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);
    hit_stat = bus_addr == ADDR_W'(OFF_STAT);
    hit_sys  = bus_addr == ADDR_W'(OFF_SYS);
    hit_tx   = bus_addr == ADDR_W'(OFF_TX);
    hit_rx   = bus_addr == ADDR_W'(OFF_RX);
  end

  assign start   = bus_we && hit_tx && sys_en && !busy;
  assign tx_byte = bus_wdata[FRAME_BITS-1:0];
  assign cs_n    = sys_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      sys_en <= 1'b0;
      sys_sw <= 1'b0;
      sys_cs <= 1'b1;
      rx_q   <= '0;
      rdy    <= 1'b0;
    end else begin
      if (bus_we && hit_ctrl && !busy) ctrl <= ctrl_t'(bus_wdata[7:0]);
      if (bus_we && hit_sys) begin
        sys_en <= bus_wdata[0];
        sys_sw <= bus_wdata[5];
        sys_cs <= bus_wdata[6];
      end
      if (done) begin
        rx_q <= rx_word;
        rdy  <= 1'b1;
      end else if (bus_re && hit_rx) begin
        rdy <= 1'b0;
      end else if (bus_we && hit_stat && !bus_wdata[2]) begin
        rdy <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata[7:0] = ctrl;
    else if (hit_stat) bus_rdata[2:0] = {rdy, 1'b0, busy};
    else if (hit_sys)  bus_rdata[6:0] = {sys_cs, sys_sw, 4'b0, sys_en};
    else if (hit_rx)   bus_rdata[FRAME_BITS-1:0] = rx_q;
  end
endmodule

// File: rtl/spi_mst_top.sv
module spi_mst_top
  import spi_mst_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int BUS_W       = 32,
  parameter int PRE_LO_LOG2 = 4,
  parameter int PRE_HI_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  ctrl_t                 ctrl;
  logic                  start, busy, done, tick, sck_ph, rdy;
  logic [FRAME_BITS-1:0] tx_byte, rx_word;

  spi_mst_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .rx_word(rx_word), .ctrl(ctrl),
    .start(start), .tx_byte(tx_byte), .cs_n(cs_n), .rdy(rdy)
  );

  spi_mst_clkgen #(.PRE_LO_LOG2(PRE_LO_LOG2), .PRE_HI_LOG2(PRE_HI_LOG2),
                   .NDIV_W(5)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .presel(ctrl.presel),
    .ndiv(ctrl.ndiv), .tick(tick)
  );

  spi_mst_shifter #(.BITS(FRAME_BITS)) u_shf (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte),
    .cpha(ctrl.cpha), .tick(tick), .miso(miso), .busy(busy),
    .done(done), .rx_word(rx_word), .sck_ph(sck_ph), .mosi(mosi)
  );

  assign sck = ctrl.cpol ^ sck_ph;
endmodule

// File: rtl/spi_mst_chk.sv
module spi_mst_chk
  import spi_mst_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              sck,
  input logic              cs_n,
  input logic              cpol,
  input logic              busy,
  input logic              rdy
);
  assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sck == cpol);

  assert_done_sets_ready_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rdy);

  assert_rx_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(OFF_RX) && !busy) |=> !rdy);

  assert_start_by_write_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_we && bus_addr == ADDR_W'(OFF_TX)));

  assert_cs_only_by_sys_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_we && bus_addr == ADDR_W'(OFF_SYS)) |-> $stable(cs_n));

  assert_ctrl_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_we && bus_addr == ADDR_W'(OFF_CTRL)) |=> $stable(cpol));
endmodule

bind spi_mst_top spi_mst_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .sck(sck), .cs_n(cs_n), .cpol(ctrl.cpol),
  .busy(busy), .rdy(rdy)
);

// File: tb/sim_spi_mst_top.sv
`timescale 1ns/1ps
module sim_spi_mst_top;
  localparam int LO = 1;
  localparam int HI = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, cs_n;
  logic        miso;

  int n_tot = 0, n_pass = 0, cycles = 0;
  logic sl_cpol = 1'b0, sl_cpha = 1'b0;
  logic [7:0] s_tx = '0;
  int         s_gen = 0;
  logic [7:0] s_rx;

  always #4 clk = !clk;

  spi_mst_top #(.PRE_LO_LOG2(LO), .PRE_HI_LOG2(HI)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  // slave model: the only driver of miso and s_rx
  int s_seen = 0, s_lead = 0, s_trail = 0;
  always @(sck or s_gen) begin
    if (s_gen != s_seen) begin
      s_seen = s_gen; s_lead = 0; s_trail = 0; s_rx = 8'h00; miso = s_tx[7];
    end else if (sck != sl_cpol) begin
      if (!sl_cpha) s_rx = {s_rx[6:0], mosi};
      else begin if (s_lead < 8) miso = s_tx[3'(7 - s_lead)]; s_lead++; end
    end else begin
      if (!sl_cpha) begin s_trail++; if (s_trail < 8) miso = s_tx[3'(7 - s_trail)]; end
      else s_rx = {s_rx[6:0], mosi};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
  endtask

  task automatic wr(input int a, input int d);
    bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_re = 1'b1; bus_addr = 5'(a);
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic arm(input logic [7:0] stx);
    s_tx = stx; s_gen++; #1;
  endtask

  task automatic set_ctrl(input logic [7:0] c);
    sl_cpha = c[7]; sl_cpol = c[6];
    wr('h00, c);
  endtask

  // wait for end of exchange; returns busy cycle count and sck toggle count
  task automatic poll(output int bn, output int tg, output logic [31:0] st);
    logic last; last = sck; bn = 0; tg = 0;
    forever begin
      rd('h04, st);
      if (sck != last) tg++;
      last = sck;
      if (!st[0] || bn > 70000) break;
      bn++;
    end
  endtask

  task automatic xfer(input logic [7:0] mtx, input logic [7:0] stx, input int exph);
    int bn, tg; logic [31:0] st, v;
    arm(stx);
    wr('h0C, mtx);
    poll(bn, tg, st);
    if (exph > 0) begin
      chk(bn == 16 * exph, "R4 busy length", bn, 16 * exph);
      chk(tg == 16, "R5 sck edges", tg, 16);
      chk(sck == sl_cpol, "R5 idle level", sck, sl_cpol);
    end
    chk(st[2] == 1'b1, "R6 ready set", st, 4);
    rd('h10, v);
    chk(v[7:0] == stx, "R6/R5 received byte", v, stx);
    chk(s_rx == mtx, "R3/R5 byte at slave", s_rx, mtx);
    rd('h04, v);
    chk(v == 0, "R6 read clears ready", v, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 190000) begin
        chk(1'b0, "watchdog", cycles, 190000);
        $display("%0d/%0d checks passed", n_pass, n_tot);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int bn, tg;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd('h00, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd('h04, v); chk(v == 0, "R1 status reset", v, 0);
    rd('h08, v); chk(v == 'h40, "R1 sys reset", v, 'h40);
    chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
    chk(sck == 1'b0, "R1 sck reset", sck, 0);
    // R3 transmit ignored while master disabled
    arm(8'h5A);
    wr('h0C, 'h33); rd('h04, v); chk(v == 0, "R3 disabled ignores tx", v, 0);
    chk(sck == 1'b0, "R3 no clock when disabled", sck, 0);
    // R2 readback masks, undefined offsets
    wr('h00, 'hFFFF_FFFF); rd('h00, v); chk(v == 'hFF, "R2 ctrl mask", v, 'hFF);
    chk(sck == 1'b1, "R5 idle follows polarity", sck, 1);
    wr('h08, 'hFFFF_FFFF); rd('h08, v); chk(v == 'h61, "R2 sys mask", v, 'h61);
    chk(cs_n == 1'b1, "R8 cs_n high", cs_n, 1);
    wr('h14, 'hFF); rd('h14, v); chk(v == 0, "R2 offset 0x14", v, 0);
    rd('h18, v); chk(v == 0, "R2 offset 0x18", v, 0);
    rd('h0C, v); chk(v == 0, "R2 tx reads zero", v, 0);
    // R8 chip select follows bit 6
    wr('h08, 'h21); chk(cs_n == 1'b0, "R8 cs_n low", cs_n, 0);
    rd('h08, v); chk(v == 'h21, "R2 sys readback", v, 'h21);
    // R4/R5 divider sweep, mode cycles with the code
    for (int s = 0; s < 64; s++) begin
      logic [7:0] c;
      c = {2'(s % 4), 6'(s)};
      set_ctrl(c);
      xfer(8'(s * 37 + 11), 8'(s * 91 + 5), (s % 32 + 1) << ((s >= 32) ? HI : LO));
    end
    // R3/R5/R6 all bytes in all modes at fastest divider
    for (int m = 0; m < 4; m++) begin
      set_ctrl({2'(m), 6'd0});
      for (int b = 0; b < 256; b++) xfer(8'(b), 8'(~b ^ (b << 3)), 0);
    end
    // R9 control and transmit writes ignored while busy
    set_ctrl(8'h03);
    arm(8'hC3);
    wr('h0C, 'hA5);
    wr('h00, 'h5F);
    wr('h0C, 'h00);
    poll(bn, tg, v);
    chk(bn + 2 == 16 * 8, "R9 timing kept", bn + 2, 128);
    chk(s_rx == 8'hA5, "R9 tx byte kept", s_rx, 'hA5);
    rd('h00, v); chk(v == 'h03, "R9 ctrl kept", v, 3);
    // R7 status write clears ready
    rd('h04, v); chk(v == 4, "R6 ready after exchange", v, 4);
    wr('h04, 'h0); rd('h04, v); chk(v == 0, "R7 status write clears", v, 0);
    rd('h10, v); chk(v == 'hC3, "R6 rx held", v, 'hC3);
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end
endmodule